// File: doc/BRIEF.md
# Variable-Length XXTEA Round Engine

This block is the iterative core of an XXTEA cipher. It encrypts or decrypts a message of 2 to 8 words of 32 bits under a 128-bit key. Each clock it carries out one partial round, which updates one word. The words sit in a circulating shift register. After each update the register rotates left, so the word being updated is always in position 0. The fresh result goes into the last valid position, where the next partial round uses it as its y or z input. A single MX function unit serves both directions. A mode multiplexer swaps its y and z operands. For decryption the words are loaded in reverse order, so the same rotation walks the message backwards.

A user drives the message, key, word count and direction and pulses `start` for one cycle. Those inputs are taken in that cycle. The engine then spends one cycle initialising the round sum, then q·n cycles of partial rounds, where q = 6 + 52/n. It finishes with a one-cycle `done` pulse. From that cycle until the next accepted start, the result stays on `dataOut` in natural word order.

Top module: `xxtea_core`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `dataOut` is all zero.
- R2: With `decrypt`=0, the result is standard XXTEA encryption of words v[0..n-1], where word i is `dataIn[32i+31:32i]` and key word k is `keyIn[32k+31:32k]`. MX = (((z>>5)^(y<<2)) + ((y>>3)^(z<<4))) ^ ((sum^y) + (key[(p&3)^e]^z)) modulo 2^32, with e = sum[3:2], and each word gains MX. Example: under an all-ones key, a8137c15 575eba50 91776d30 gives ef1c60b2 72b778b0 6abaccab.
- R3: With `decrypt`=1, the result is standard XXTEA decryption: the initial sum is q·0x9e3779b9, each word loses MX, and the words are walked in reverse. Decrypting a ciphertext returns the plaintext.
- R4: Every word count from 2 to 8 works, with q = 6 + 52/n full rounds of n partial rounds each. The `dataOut` words at index n and above read zero.
- R5: If `start` is sampled at clock edge k while idle, `done` is high exactly between edges k+q·n+1 and k+q·n+2.
- R6: `busy` is high from edge k through the `done` cycle and low after it. `done` lasts one clock.
- R7: While `busy` is high, `start` and every change on `decrypt`, `numWords`, `keyIn` and `dataIn` have no effect on the result or the timing.
- R8: A `numWords` value below 2 is treated as 2. A value above 8 is treated as 8.
- R9: While idle and with no `start`, `dataOut` holds the last result unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; taken only when idle |
| decrypt | input | 1 | 1 selects decryption, 0 encryption |
| numWords | input | 4 | Message length in 32-bit words (clamped to 2..8) |
| keyIn | input | 128 | Key, word k at bits 32k+31:32k |
| dataIn | input | 256 | Message, word i at bits 32i+31:32i |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| dataOut | output | 256 | Result in natural word order, unused words zero |

## Verification
A fault in the rotation, the y/z swap or the key index corrupts the words that are updated after it. Because every later partial round chains through those words, the fault spreads to the whole result by the `done` pulse and shows up as a ciphertext mismatch or a failed round trip. A wrong sum start value or sum step shows up the same way, for the chosen word count. A counter off by one shifts the `done` pulse by at least one clock, and the per-clock comparison of `busy` and `done` catches that in the cycle it happens. A start that leaks through while busy disturbs either the timing or the result of that same operation.

// File: rtl/xxtea_pkg.sv
package xxtea_pkg;
  localparam int WORD_W     = 32;
  localparam int MAX_WORDS  = 8;
  localparam int MIN_WORDS  = 2;
  localparam int CNT_W      = $clog2(MAX_WORDS + 1);
  localparam int MAX_ROUNDS = 6 + 52 / MIN_WORDS;
  localparam int ROUND_W    = $clog2(MAX_ROUNDS + 1);
  localparam logic [WORD_W-1:0] DELTA = 32'h9e3779b9;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_DONE} engState_t;

  // Strobes from control towards key schedule and datapath
  typedef struct packed {
    logic             load;     // capture inputs
    logic             init;     // set initial round sum
    logic             step;     // perform one partial round
    logic             lastSub;  // current partial round closes a round
    logic [CNT_W-1:0] subIdx;   // partial round index inside the round
  } ctrlStrobe_t;

  function automatic logic [WORD_W-1:0] mixWord(input logic [WORD_W-1:0] y,
                                                input logic [WORD_W-1:0] z,
                                                input logic [WORD_W-1:0] sum,
                                                input logic [WORD_W-1:0] key);
    return (((z >> 5) ^ (y << 2)) + ((y >> 3) ^ (z << 4))) ^ ((sum ^ y) + (key ^ z));
  endfunction

  function automatic logic [CNT_W-1:0] clampWords(input logic [CNT_W-1:0] n);
    if (n < CNT_W'(MIN_WORDS)) return CNT_W'(MIN_WORDS);
    if (n > CNT_W'(MAX_WORDS)) return CNT_W'(MAX_WORDS);
    return n;
  endfunction

  function automatic logic [ROUND_W-1:0] roundsFor(input logic [CNT_W-1:0] n);
    logic [ROUND_W-1:0] r;
    r = ROUND_W'(MAX_ROUNDS);
    for (int k = MIN_WORDS; k <= MAX_WORDS; k++)
      if (n == CNT_W'(k)) r = ROUND_W'(6 + 52 / k);
    return r;
  endfunction

  // Decryption start sum q*DELTA, selected from constants per word count
  function automatic logic [WORD_W-1:0] decSumFor(input logic [CNT_W-1:0] n);
    logic [WORD_W-1:0] s;
    s = '0;
    for (int k = MIN_WORDS; k <= MAX_WORDS; k++)
      if (n == CNT_W'(k)) s = WORD_W'(6 + 52 / k) * DELTA;
    return s;
  endfunction
endpackage

// File: rtl/xxtea_ctrl.sv
module xxtea_ctrl
  import xxtea_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             decIn,
  input  logic [CNT_W-1:0] nIn,
  output ctrlStrobe_t      strb,
  output logic             decMode,
  output logic [CNT_W-1:0] nWords,
  output logic             busy,
  output logic             done
);
  engState_t          state;
  logic [CNT_W-1:0]   subCnt;
  logic [ROUND_W-1:0] roundCnt;
  logic [ROUND_W-1:0] roundTotal;
  logic               lastSub;
  logic               lastRound;

  assign roundTotal = roundsFor(nWords);
  assign lastSub    = (subCnt == nWords - CNT_W'(1));
  assign lastRound  = (roundCnt == roundTotal - ROUND_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      decMode  <= 1'b0;
      nWords   <= CNT_W'(MIN_WORDS);
      subCnt   <= '0;
      roundCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          decMode <= decIn;
          nWords  <= nIn;
          state   <= ST_LOAD;
        end
        ST_LOAD: begin
          subCnt   <= '0;
          roundCnt <= '0;
          state    <= ST_RUN;
        end
        ST_RUN: begin
          if (lastSub) begin
            subCnt <= '0;
            if (lastRound) state <= ST_DONE;
            else           roundCnt <= roundCnt + ROUND_W'(1);
          end else begin
            subCnt <= subCnt + CNT_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = (state == ST_IDLE) && start;
    strb.init    = (state == ST_LOAD);
    strb.step    = (state == ST_RUN);
    strb.lastSub = lastSub;
    strb.subIdx  = subCnt;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/xxtea_keysched.sv
module xxtea_keysched
  import xxtea_pkg::*;
#(
  parameter int KEY_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strb,
  input  logic [KEY_WORDS*WORD_W-1:0] keyIn,
  input  logic                        decMode,
  input  logic [CNT_W-1:0]            nWords,
  output logic [WORD_W-1:0]           sum,
  output logic [WORD_W-1:0]           subKey
);
  localparam int KIDX_W = $clog2(KEY_WORDS);

  logic [KEY_WORDS*WORD_W-1:0] keyReg;
  logic [KIDX_W-1:0]           pLow;
  logic [KIDX_W-1:0]           keyIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg <= '0;
      sum    <= '0;
    end else begin
      if (strb.load) keyReg <= keyIn;
      if (strb.init) sum <= decMode ? decSumFor(nWords) : DELTA;
      else if (strb.step && strb.lastSub) sum <= decMode ? sum - DELTA : sum + DELTA;
    end
  end

  // word index p: forward in encryption, backward in decryption
  assign pLow   = decMode ? KIDX_W'(nWords - CNT_W'(1) - strb.subIdx) : strb.subIdx[KIDX_W-1:0];
  assign keyIdx = pLow ^ sum[2 +: KIDX_W];

  always_comb begin
    subKey = '0;
    for (int k = 0; k < KEY_WORDS; k++)
      if (keyIdx == KIDX_W'(k)) subKey = keyReg[k*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/xxtea_datapath.sv
module xxtea_datapath
  import xxtea_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        loadEn,
  input  logic                        stepEn,
  input  logic [MAX_WORDS*WORD_W-1:0] dataIn,
  input  logic                        decIn,
  input  logic [CNT_W-1:0]            nIn,
  input  logic                        decMode,
  input  logic [CNT_W-1:0]            nWords,
  input  logic [WORD_W-1:0]           sum,
  input  logic [WORD_W-1:0]           subKey,
  output logic [MAX_WORDS*WORD_W-1:0] dataOut
);
  logic [WORD_W-1:0] pos      [MAX_WORDS];
  logic [WORD_W-1:0] loadWord [MAX_WORDS];
  logic [WORD_W-1:0] lastWord;
  logic [WORD_W-1:0] yIn, zIn, mixVal, updWord;
  logic [CNT_W-1:0]  lastIdx;

  assign lastIdx = nWords - CNT_W'(1);

  // word at the last valid position = most recently updated word
  always_comb begin
    lastWord = '0;
    for (int k = 0; k < MAX_WORDS; k++)
      if (lastIdx == CNT_W'(k)) lastWord = pos[k];
  end

  // mode mux swaps the roles of neighbour and last-updated word
  assign yIn     = decMode ? lastWord : pos[1];
  assign zIn     = decMode ? pos[1]   : lastWord;
  assign mixVal  = mixWord(yIn, zIn, sum, subKey);
  assign updWord = decMode ? pos[0] - mixVal : pos[0] + mixVal;

  // load: natural order for encryption, reversed for decryption
  always_comb begin
    for (int i = 0; i < MAX_WORDS; i++) begin
      loadWord[i] = '0;
      for (int j = 0; j < MAX_WORDS; j++) begin
        if (CNT_W'(i) < nIn) begin
          if (decIn ? (nIn - CNT_W'(1) - CNT_W'(i) == CNT_W'(j)) : (i == j))
            loadWord[i] = dataIn[j*WORD_W +: WORD_W];
        end
      end
    end
  end

  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_pos
    if (i < MAX_WORDS - 1) begin : g_mid
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       pos[i] <= '0;
        else if (loadEn) pos[i] <= loadWord[i];
        else if (stepEn) begin
          if (CNT_W'(i) == lastIdx)     pos[i] <= updWord;
          else if (CNT_W'(i) < lastIdx) pos[i] <= pos[i+1];
        end
      end
    end else begin : g_top
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       pos[i] <= '0;
        else if (loadEn) pos[i] <= loadWord[i];
        else if (stepEn && (CNT_W'(i) == lastIdx)) pos[i] <= updWord;
      end
    end
  end

  // result in natural word order, unused words zero
  always_comb begin
    dataOut = '0;
    for (int i = 0; i < MAX_WORDS; i++) begin
      for (int j = 0; j < MAX_WORDS; j++) begin
        if (CNT_W'(i) < nWords) begin
          if (decMode ? (lastIdx - CNT_W'(i) == CNT_W'(j)) : (i == j))
            dataOut[i*WORD_W +: WORD_W] = pos[j];
        end
      end
    end
  end
endmodule

// File: rtl/xxtea_core.sv
module xxtea_core
  import xxtea_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        decrypt,
  input  logic [CNT_W-1:0]            numWords,
  input  logic [4*WORD_W-1:0]         keyIn,
  input  logic [MAX_WORDS*WORD_W-1:0] dataIn,
  output logic                        busy,
  output logic                        done,
  output logic [MAX_WORDS*WORD_W-1:0] dataOut
);
  ctrlStrobe_t       strb;
  logic              decMode;
  logic [CNT_W-1:0]  nWords;
  logic [CNT_W-1:0]  nClamped;
  logic [WORD_W-1:0] sum;
  logic [WORD_W-1:0] subKey;

  assign nClamped = clampWords(numWords);

  xxtea_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .decIn(decrypt), .nIn(nClamped),
    .strb(strb), .decMode(decMode), .nWords(nWords), .busy(busy), .done(done)
  );

  xxtea_keysched #(.KEY_WORDS(4)) u_keys (
    .clk(clk), .rstN(rstN), .strb(strb), .keyIn(keyIn), .decMode(decMode),
    .nWords(nWords), .sum(sum), .subKey(subKey)
  );

  xxtea_datapath u_dp (
    .clk(clk), .rstN(rstN), .loadEn(strb.load), .stepEn(strb.step),
    .dataIn(dataIn), .decIn(decrypt), .nIn(nClamped), .decMode(decMode),
    .nWords(nWords), .sum(sum), .subKey(subKey), .dataOut(dataOut)
  );
endmodule

// File: rtl/xxtea_core_chk.sv
module xxtea_core_chk
  import xxtea_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        start,
  input logic                        busy,
  input logic                        done,
  input logic [MAX_WORDS*WORD_W-1:0] dataOut
);
  // R6: done lasts a single clock
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R6: done only while busy, and the engine is idle right after
  a_r6_done_busy:   assert property (@(posedge clk) disable iff (!rstN) done |-> busy);
  a_r6_idle_after:  assert property (@(posedge clk) disable iff (!rstN) done |=> !busy);
  // R7: once busy, nothing but completion ends the operation
  a_r7_stay_busy:   assert property (@(posedge clk) disable iff (!rstN) (busy && !done) |=> busy);
  // R9: idle without start keeps the result
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rstN)
                                     (!busy && !start) |=> $stable(dataOut));
endmodule

bind xxtea_core xxtea_core_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .dataOut(dataOut)
);

// File: tb/xxtea_core_bench.sv
module xxtea_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DLT = 32'h9e3779b9;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic [3:0]   numWords = 4'd2;
  logic [127:0] keyIn = '0;
  logic [255:0] dataIn = '0;
  logic         busy, done;
  logic [255:0] dataOut;

  int checks = 0;
  int failures = 0;

  xxtea_core u_xxtea_core (
    .clk(clk), .rstN(rstN), .start(start), .decrypt(decrypt), .numWords(numWords),
    .keyIn(keyIn), .dataIn(dataIn), .busy(busy), .done(done), .dataOut(dataOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mxRef(logic [31:0] y, logic [31:0] z, logic [31:0] s, logic [31:0] k);
    logic [31:0] a, b;
    a = ((z >> 5) ^ (y << 2)) + ((y >> 3) ^ (z << 4));
    b = (s ^ y) + (k ^ z);
    return a ^ b;
  endfunction

  // behavioural XXTEA on a word list
  function automatic logic [255:0] refCipher(bit dec, int n, logic [127:0] key, logic [255:0] din);
    logic [31:0] v[8];
    logic [31:0] k[4];
    logic [31:0] s, y, z;
    logic [255:0] r;
    int q, e;
    for (int i = 0; i < 8; i++) v[i] = (i < n) ? din[32*i +: 32] : 32'h0;
    for (int i = 0; i < 4; i++) k[i] = key[32*i +: 32];
    q = 6 + 52 / n;
    if (!dec) begin
      s = 0; z = v[n-1];
      for (int r2 = 0; r2 < q; r2++) begin
        s = s + DLT; e = int'((s >> 2) & 3);
        for (int p = 0; p < n; p++) begin
          y = v[(p + 1) % n];
          v[p] = v[p] + mxRef(y, z, s, k[(p & 3) ^ e]);
          z = v[p];
        end
      end
    end else begin
      s = 32'(q) * DLT; y = v[0];
      for (int r2 = 0; r2 < q; r2++) begin
        e = int'((s >> 2) & 3);
        for (int p = n - 1; p >= 0; p--) begin
          z = v[(p + n - 1) % n];
          v[p] = v[p] - mxRef(y, z, s, k[(p & 3) ^ e]);
          y = v[p];
        end
        s = s - DLT;
      end
    end
    r = '0;
    for (int i = 0; i < n; i++) r[32*i +: 32] = v[i];
    return r;
  endfunction

  // run one operation, compare busy/done on every clock, return result at done
  task automatic runOp(input bit dec, input logic [3:0] nPort, input int nEff,
                       input logic [255:0] din, input logic [127:0] key,
                       input bit disturb, output logic [255:0] result);
    int len;
    len = (6 + 52 / nEff) * nEff;
    result = '0;
    @(negedge clk);
    start = 1'b1; decrypt = dec; numWords = nPort; keyIn = key; dataIn = din;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= len + 2; j++) begin
      chk(busy == (j <= len + 1), $sformatf("R6 busy at cycle %0d", j), 256'(busy), 256'(j <= len + 1));
      chk(done == (j == len + 1), $sformatf("R5 done at cycle %0d", j), 256'(done), 256'(j == len + 1));
      if (j == len + 1) result = dataOut;
      if (disturb && j == 5) begin
        start = 1'b1; decrypt = ~dec; numWords = ~nPort; dataIn = ~din; keyIn = ~key;
      end
      if (disturb && j == 6) start = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [255:0] res, res2, pt, expv;
    logic [127:0] key;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", 256'(busy), 256'(0));
    chk(done == 1'b0, "R1 done after reset", 256'(done), 256'(0));
    chk(dataOut == '0, "R1 dataOut after reset", dataOut, '0);

    // R2 / R3 known 3-word vector
    key = {4{32'hffffffff}};
    pt  = {160'h0, 32'h91776d30, 32'h575eba50, 32'ha8137c15};
    expv = {160'h0, 32'h6abaccab, 32'h72b778b0, 32'hef1c60b2};
    runOp(1'b0, 4'd3, 3, pt, key, 1'b0, res);
    chk(res == expv, "R2 known vector encrypt", res, expv);
    runOp(1'b1, 4'd3, 3, {~160'h0, res[95:0]}, key, 1'b0, res2);
    chk(res2 == pt, "R3 known vector decrypt", res2, pt);

    // R4 every word count, encrypt and decrypt against model, round trip
    for (int n = 2; n <= 8; n++) begin
      for (int i = 0; i < 8; i++) pt[32*i +: 32] = 32'h1357_9bdf * 32'(i + n) ^ 32'(n << 20);
      key = {32'h08040201 ^ 32'(n), 32'h80402010, 32'hf8fcfeff, 32'h80c0e0f0 + 32'(n)};
      expv = refCipher(1'b0, n, key, pt);
      runOp(1'b0, 4'(n), n, pt, key, 1'b0, res);
      chk(res == expv, $sformatf("R2 R4 encrypt n=%0d", n), res, expv);
      expv = refCipher(1'b1, n, key, pt);
      runOp(1'b1, 4'(n), n, pt, key, 1'b0, res2);
      chk(res2 == expv, $sformatf("R3 R4 decrypt n=%0d", n), res2, expv);
      runOp(1'b1, 4'(n), n, res, key, 1'b0, res2);
      expv = refCipher(1'b0, 8, 128'h0, 256'h0);
      expv = '0;
      for (int i = 0; i < n; i++) expv[32*i +: 32] = pt[32*i +: 32];
      chk(res2 == expv, $sformatf("R3 R4 round trip n=%0d", n), res2, expv);
    end

    // R8 clamping of the word count
    pt = 256'h0123456789abcdef_fedcba9876543210_0f1e2d3c4b5a6978_8796a5b4c3d2e1f0;
    key = 128'hdeadbeef_0badf00d_cafebabe_12345678;
    expv = refCipher(1'b0, 2, key, pt);
    runOp(1'b0, 4'd0, 2, pt, key, 1'b0, res);
    chk(res == expv, "R8 count 0 acts as 2", res, expv);
    runOp(1'b0, 4'd1, 2, pt, key, 1'b0, res);
    chk(res == expv, "R8 count 1 acts as 2", res, expv);
    expv = refCipher(1'b0, 8, key, pt);
    runOp(1'b0, 4'd15, 8, pt, key, 1'b0, res);
    chk(res == expv, "R8 count 15 acts as 8", res, expv);

    // R7 start and input changes during a run are ignored
    expv = refCipher(1'b1, 5, key, pt);
    runOp(1'b1, 4'd5, 5, pt, key, 1'b1, res);
    chk(res == expv, "R7 disturbed run result", res, expv);

    // R9 result held while idle with changing inputs
    dataIn = ~dataIn; keyIn = ~keyIn; decrypt = ~decrypt; numWords = 4'd7;
    repeat (4) begin
      @(negedge clk);
      chk(dataOut == expv, "R9 result held while idle", dataOut, expv);
      dataIn = dataIn + 256'd12345;
    end
    chk(busy == 1'b0, "R7 R9 no operation started", 256'(busy), 256'(0));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule